// File: doc/BRIEF.md
# Outbound Address Window Translator

This block maps addresses issued on the processor side of a host bridge into addresses on the PCIe side. It holds a small set of outbound windows. Each window is described by an inclusive range of processor-side megabytes (a start and an end) and a 64-bit PCIe base. A request address is compared with every window in parallel. When one or more windows claim it, the lowest-numbered of them is chosen. The output address is that window's PCIe base plus the request's distance from the window start.

Windows are programmed through a simple word-indexed write port. Each megabyte bound is split into two parts: a 12-bit lower part, which shares one register word with the other bound, and an 8-bit upper part, which sits in a register of its own. Processor addresses are therefore 40 bits wide. The result of a request is registered and appears one cycle after the request. It is either a hit, carrying the window number and the translated address, or a miss flag.

The response side is a three-state machine. The state register moves to `RS_IDLE` on a cycle with no request. It moves to `RS_HIT` on a request that some window claims (transition "claim") and to `RS_MISS` on a request that no window claims (transition "reject"). Every state can reach every other state in one cycle. The outputs are decoded from the current state alone.

Top module: `owt_xlate`

## Requirements
- R1: After reset, each window's start fields read all ones and its end fields read zero, so every window is disabled. Every request made before any programming is answered as a miss, and `rsp_valid` is low during reset.
- R2: Register word index = window × 8 + offset. Offset 0 holds PCIe base bits [31:0]. Offset 1 holds PCIe base bits [63:32]. Offset 2 carries start-MB[11:0] in data bits [15:4] and end-MB[11:0] in data bits [31:20]. Offset 3 carries start-MB[19:12] in data bits [7:0]. Offset 4 carries end-MB[19:12] in data bits [7:0]. All other data bits in offsets 2–4, and all writes to offsets 5–7, have no effect.
- R3: A window claims a request when start-MB ≤ `req_addr[39:20]` ≤ end-MB, and both bounds are inclusive.
- R4: The translated address is PCIe base + `req_addr` − start-MB × 2^20, taken modulo 2^64.
- R5: When several windows claim an address, the lowest-numbered window is reported.
- R6: A window whose end-MB is below its start-MB never claims any address.
- R7: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high. In a cycle that follows no request, `rsp_valid`, `rsp_hit` and `rsp_miss` are all low.
- R8: A response has exactly one of `rsp_hit` and `rsp_miss` set. On a miss, `rsp_win` and `rsp_addr` are zero.
- R9: A configuration write changes the translation of requests made in later cycles. A request made in the same cycle as the write is translated with the values held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 5 | Configuration word index (window × 8 + offset) |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 40 | Processor-side request address |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_hit | output | 1 | Request was claimed by a window |
| rsp_miss | output | 1 | No window claimed the request |
| rsp_win | output | 2 | Index of the claiming window |
| rsp_addr | output | 64 | Translated PCIe-side address |

## Verification
The bound checker examines every cycle. It checks that each response follows a request by one cycle, that hit and miss exclude each other, and that a miss carries zero fields. For each hit it checks that the reported window was enabled and claimed the address. It also checks that no lower-numbered window claimed the same address, and that the output address equals the window base plus the offset, using the window values captured at the request edge. Other behaviours can only be shown by the bench's scenarios: the reset contents, the split field layout with its ignored bits and offsets, the 64-bit wrap of the adder, and the rule that a write in the same cycle as a request does not affect it. The bench shows these with a dense sweep around window edges, overlaps and the 12-bit field boundary.

// File: rtl/owt_pkg.sv
package owt_pkg;
    localparam int unsigned MB_SHIFT   = 20;
    localparam int unsigned OFS_W      = 3;
    localparam int unsigned PCIE_AW    = 64;
    localparam int unsigned CFG_DW     = 32;

    typedef enum logic [OFS_W-1:0] {
        OFS_PCIE_LO    = 3'd0,
        OFS_PCIE_HI    = 3'd1,
        OFS_BOUNDS_LO  = 3'd2,
        OFS_START_HI   = 3'd3,
        OFS_END_HI     = 3'd4
    } cfg_ofs_e;

    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,
        RS_HIT  = 2'd1,
        RS_MISS = 2'd2
    } rsp_state_e;
endpackage

// File: rtl/owt_win_regs.sv
module owt_win_regs
    import owt_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int MB_LO_W = 12,
    parameter int MB_HI_W = 8,
    localparam int MB_W   = MB_LO_W + MB_HI_W,
    localparam int WIN_IW = $clog2(NUM_WIN),
    localparam int CFG_IW = WIN_IW + OFS_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [CFG_IW-1:0]                 cfg_idx,
    input  logic [CFG_DW-1:0]                 cfg_wdata,
    output logic [NUM_WIN-1:0][MB_W-1:0]      start_mb,
    output logic [NUM_WIN-1:0][MB_W-1:0]      end_mb,
    output logic [NUM_WIN-1:0][PCIE_AW-1:0]   pcie_base
);
    localparam int START_LO_POS = 4;
    localparam int END_LO_POS   = CFG_DW - MB_LO_W;

    logic [OFS_W-1:0]  ofs;
    logic [WIN_IW-1:0] slot;

    assign ofs  = cfg_idx[OFS_W-1:0];
    assign slot = cfg_idx[CFG_IW-1:OFS_W];

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        logic [MB_LO_W-1:0] start_lo_q, end_lo_q;
        logic [MB_HI_W-1:0] start_hi_q, end_hi_q;
        logic [CFG_DW-1:0]  base_lo_q, base_hi_q;
        logic               sel;

        assign sel = cfg_we && (slot == WIN_IW'(w));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                start_lo_q <= '1;
                start_hi_q <= '1;
                end_lo_q   <= '0;
                end_hi_q   <= '0;
                base_lo_q  <= '0;
                base_hi_q  <= '0;
            end else if (sel) begin
                case (ofs)
                    OFS_PCIE_LO:   base_lo_q <= cfg_wdata;
                    OFS_PCIE_HI:   base_hi_q <= cfg_wdata;
                    OFS_BOUNDS_LO: begin
                        start_lo_q <= cfg_wdata[START_LO_POS +: MB_LO_W];
                        end_lo_q   <= cfg_wdata[END_LO_POS +: MB_LO_W];
                    end
                    OFS_START_HI:  start_hi_q <= cfg_wdata[MB_HI_W-1:0];
                    OFS_END_HI:    end_hi_q   <= cfg_wdata[MB_HI_W-1:0];
                    default: ;
                endcase
            end
        end

        assign start_mb[w]  = {start_hi_q, start_lo_q};
        assign end_mb[w]    = {end_hi_q, end_lo_q};
        assign pcie_base[w] = {base_hi_q, base_lo_q};
    end
endmodule

// File: rtl/owt_win_match.sv
module owt_win_match #(
    parameter int NUM_WIN = 4,
    parameter int MB_W    = 20
) (
    input  logic [MB_W-1:0]                addr_mb,
    input  logic [NUM_WIN-1:0][MB_W-1:0]   start_mb,
    input  logic [NUM_WIN-1:0][MB_W-1:0]   end_mb,
    output logic [NUM_WIN-1:0]             claim
);
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
        logic above_start, below_end;
        assign above_start = (addr_mb >= start_mb[w]);
        assign below_end   = (addr_mb <= end_mb[w]);
        // an inverted window cannot satisfy both bounds at once
        assign claim[w]    = above_start && below_end;
    end
endmodule

// File: rtl/owt_pick.sv
module owt_pick
    import owt_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int MB_W    = 20,
    localparam int WIN_IW = $clog2(NUM_WIN),
    localparam int CPU_AW = MB_W + MB_SHIFT
) (
    input  logic [NUM_WIN-1:0]                claim,
    input  logic [CPU_AW-1:0]                 addr,
    input  logic [NUM_WIN-1:0][MB_W-1:0]      start_mb,
    input  logic [NUM_WIN-1:0][PCIE_AW-1:0]   pcie_base,
    output logic                              any_claim,
    output logic [WIN_IW-1:0]                 win_idx,
    output logic [PCIE_AW-1:0]                xlat_addr
);
    logic [MB_W-1:0]    sel_start;
    logic [CPU_AW-1:0]  delta;

    always_comb begin
        any_claim = 1'b0;
        win_idx   = '0;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (claim[w]) begin
                any_claim = 1'b1;
                win_idx   = WIN_IW'(w);
            end
        end
    end

    assign sel_start = start_mb[win_idx];
    assign delta     = addr - {sel_start, {MB_SHIFT{1'b0}}};
    assign xlat_addr = pcie_base[win_idx] + PCIE_AW'(delta);
endmodule

// File: rtl/owt_xlate.sv
module owt_xlate
    import owt_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int MB_LO_W = 12,
    parameter int MB_HI_W = 8,
    localparam int MB_W   = MB_LO_W + MB_HI_W,
    localparam int WIN_IW = $clog2(NUM_WIN),
    localparam int CFG_IW = WIN_IW + OFS_W,
    localparam int CPU_AW = MB_W + MB_SHIFT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_IW-1:0]    cfg_idx,
    input  logic [CFG_DW-1:0]    cfg_wdata,
    input  logic                 req_valid,
    input  logic [CPU_AW-1:0]    req_addr,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic                 rsp_miss,
    output logic [WIN_IW-1:0]    rsp_win,
    output logic [PCIE_AW-1:0]   rsp_addr
);
    logic [NUM_WIN-1:0][MB_W-1:0]    win_start_mb;
    logic [NUM_WIN-1:0][MB_W-1:0]    win_end_mb;
    logic [NUM_WIN-1:0][PCIE_AW-1:0] win_pcie_base;
    logic [NUM_WIN-1:0]              claim;
    logic                            any_claim;
    logic [WIN_IW-1:0]               pick_idx;
    logic [PCIE_AW-1:0]              pick_addr;

    rsp_state_e          state_q, state_d;
    logic [WIN_IW-1:0]   win_q;
    logic [PCIE_AW-1:0]  addr_q;

    owt_win_regs #(
        .NUM_WIN (NUM_WIN),
        .MB_LO_W (MB_LO_W),
        .MB_HI_W (MB_HI_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .start_mb  (win_start_mb),
        .end_mb    (win_end_mb),
        .pcie_base (win_pcie_base)
    );

    owt_win_match #(
        .NUM_WIN (NUM_WIN),
        .MB_W    (MB_W)
    ) u_match (
        .addr_mb  (req_addr[CPU_AW-1:MB_SHIFT]),
        .start_mb (win_start_mb),
        .end_mb   (win_end_mb),
        .claim    (claim)
    );

    owt_pick #(
        .NUM_WIN (NUM_WIN),
        .MB_W    (MB_W)
    ) u_pick (
        .claim     (claim),
        .addr      (req_addr),
        .start_mb  (win_start_mb),
        .pcie_base (win_pcie_base),
        .any_claim (any_claim),
        .win_idx   (pick_idx),
        .xlat_addr (pick_addr)
    );

    // next-state: claim -> RS_HIT, reject -> RS_MISS, no request -> RS_IDLE
    always_comb begin
        state_d = RS_IDLE;
        if (req_valid) begin
            state_d = any_claim ? RS_HIT : RS_MISS;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q  <= '0;
            addr_q <= '0;
        end else if (req_valid && any_claim) begin
            win_q  <= pick_idx;
            addr_q <= pick_addr;
        end else begin
            win_q  <= '0;
            addr_q <= '0;
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_hit   = 1'b0;
        rsp_miss  = 1'b0;
        unique case (state_q)
            RS_IDLE: ;
            RS_HIT: begin
                rsp_valid = 1'b1;
                rsp_hit   = 1'b1;
            end
            RS_MISS: begin
                rsp_valid = 1'b1;
                rsp_miss  = 1'b1;
            end
            default: ;
        endcase
    end

    assign rsp_win  = win_q;
    assign rsp_addr = addr_q;
endmodule

// File: rtl/owt_xlate_chk.sv
module owt_xlate_chk
    import owt_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int MB_W    = 20,
    localparam int WIN_IW = $clog2(NUM_WIN),
    localparam int CPU_AW = MB_W + MB_SHIFT
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    input  logic [CPU_AW-1:0]                 req_addr,
    input  logic                              rsp_valid,
    input  logic                              rsp_hit,
    input  logic                              rsp_miss,
    input  logic [WIN_IW-1:0]                 rsp_win,
    input  logic [PCIE_AW-1:0]                rsp_addr,
    input  logic [NUM_WIN-1:0][MB_W-1:0]      start_mb,
    input  logic [NUM_WIN-1:0][MB_W-1:0]      end_mb,
    input  logic [NUM_WIN-1:0][PCIE_AW-1:0]   pcie_base
);
    logic [CPU_AW-1:0]                 cap_addr;
    logic [NUM_WIN-1:0][MB_W-1:0]      cap_start;
    logic [NUM_WIN-1:0][MB_W-1:0]      cap_end;
    logic [NUM_WIN-1:0][PCIE_AW-1:0]   cap_base;

    always_ff @(posedge clk) begin
        cap_addr  <= req_addr;
        cap_start <= start_mb;
        cap_end   <= end_mb;
        cap_base  <= pcie_base;
    end

    logic [MB_W-1:0]    cap_mb;
    logic               win_claims, win_enabled, lower_claims;
    logic [PCIE_AW-1:0] want_addr;

    assign cap_mb = cap_addr[CPU_AW-1:MB_SHIFT];

    always_comb begin
        win_claims   = 1'b0;
        win_enabled  = 1'b0;
        lower_claims = 1'b0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (w == int'(rsp_win)) begin
                win_claims  = (cap_mb >= cap_start[w]) && (cap_mb <= cap_end[w]);
                win_enabled = (cap_end[w] >= cap_start[w]);
            end
            if (w < int'(rsp_win) && cap_mb >= cap_start[w] && cap_mb <= cap_end[w]) begin
                lower_claims = 1'b1;
            end
        end
    end

    assign want_addr = cap_base[rsp_win]
                     + PCIE_AW'(cap_addr - {cap_start[rsp_win], {MB_SHIFT{1'b0}}});

    p_resp_after_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_quiet_after_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_miss));

    p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot({rsp_hit, rsp_miss}));

    p_miss_zeroed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_win == '0 && rsp_addr == '0));

    p_hit_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> win_claims);

    p_hit_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> win_enabled);

    p_lowest_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> !lower_claims);

    p_offset_added_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_addr == want_addr));
endmodule

bind owt_xlate owt_xlate_chk #(
    .NUM_WIN (NUM_WIN),
    .MB_W    (MB_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_miss  (rsp_miss),
    .rsp_win   (rsp_win),
    .rsp_addr  (rsp_addr),
    .start_mb  (win_start_mb),
    .end_mb    (win_end_mb),
    .pcie_base (win_pcie_base)
);

// File: tb/owt_xlate_test.sv
`timescale 1ns/1ps
module owt_xlate_test;
    localparam int NW = 4;
    localparam int AW = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic        rsp_valid, rsp_hit, rsp_miss;
    logic [1:0]  rsp_win;
    logic [63:0] rsp_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [19:0] sh_start [NW];
    logic [19:0] sh_end   [NW];
    logic [63:0] sh_base  [NW];

    always #10 clk = ~clk;

    owt_xlate uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_miss  (rsp_miss),
        .rsp_win   (rsp_win),
        .rsp_addr  (rsp_addr)
    );

    task automatic check_rsp(input string tag, input logic v, input logic h,
                             input logic m, input logic [1:0] w, input logic [63:0] x);
        checks++;
        if ({rsp_valid, rsp_hit, rsp_miss, rsp_win, rsp_addr} !== {v, h, m, w, x}) begin
            fails++;
            $display("FAIL %s: got v=%b h=%b m=%b win=%0d addr=%h, expected v=%b h=%b m=%b win=%0d addr=%h",
                     tag, rsp_valid, rsp_hit, rsp_miss, rsp_win, rsp_addr, v, h, m, w, x);
        end
    endtask

    task automatic model(input logic [AW-1:0] a, output logic h,
                         output logic [1:0] w, output logic [63:0] x);
        logic [19:0] mb;
        mb = a[39:20];
        h = 1'b0; w = '0; x = '0;
        for (int i = 0; i < NW; i++) begin
            if (!h && sh_start[i] <= mb && mb <= sh_end[i]) begin
                h = 1'b1;
                w = 2'(i);
                x = sh_base[i] + {24'h0, a} - {24'h0, sh_start[i], 20'h0};
            end
        end
    endtask

    task automatic cfg_wr(input logic [4:0] idx, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic program_win(input int w, input logic [19:0] s,
                               input logic [19:0] e, input logic [63:0] b);
        logic [4:0] blk;
        blk = 5'(w * 8);
        cfg_wr(blk + 5'd0, b[31:0]);
        cfg_wr(blk + 5'd1, b[63:32]);
        cfg_wr(blk + 5'd2, {e[11:0], 4'hA, s[11:0], 4'h5});
        cfg_wr(blk + 5'd3, {24'hC3C3C3, s[19:12]});
        cfg_wr(blk + 5'd4, {24'h5A5A5A, e[19:12]});
        sh_start[w] = s; sh_end[w] = e; sh_base[w] = b;
    endtask

    task automatic apply(input string tag, input logic [AW-1:0] a);
        logic h; logic [1:0] w; logic [63:0] x;
        model(a, h, w, x);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp(tag, 1'b1, h, !h, w, x);
    endtask

    function automatic logic [AW-1:0] mk_addr(input logic [19:0] mb);
        logic [19:0] low;
        low = 20'(mb * 20'h3A5C7 + 20'h123);
        return {mb, low};
    endfunction

    initial begin
        logic h; logic [1:0] w; logic [63:0] x;
        logic [AW-1:0] a0, a1;
        for (int i = 0; i < NW; i++) begin
            sh_start[i] = 20'hFFFFF; sh_end[i] = '0; sh_base[i] = '0;
        end
        repeat (3) @(negedge clk);
        check_rsp("R1 reset outputs", 1'b0, 1'b0, 1'b0, 2'd0, 64'd0);
        rst_n = 1'b1;
        // R1: all windows disabled out of reset
        apply("R1 unprogrammed low", 40'h00_0000_1234);
        apply("R1 unprogrammed top", 40'hFF_FFFF_FFFF);
        apply("R1 unprogrammed mid", 40'h01_0000_0000);

        program_win(0, 20'h00010, 20'h0001F, 64'h0000_0001_0000_0000);
        program_win(1, 20'h00018, 20'h0002F, 64'h0000_0000_8000_0000);
        program_win(2, 20'h00FF0, 20'h01010, 64'hFFFF_FFFF_FFF0_0000);
        program_win(3, 20'h00040, 20'h0003F, 64'h0000_00AB_0000_0000);

        // near-exhaustive sweep across windows 0, 1, 3
        for (int mb = 0; mb < 'h50; mb++) begin
            logic [AW-1:0] a;
            a = mk_addr(20'(mb));
            model(a, h, w, x);
            if (mb >= 'h3F && mb <= 'h40)      apply("R6 inverted window", a);
            else if (!h)                      apply("R8 miss", a);
            else if (mb >= 'h18 && mb <= 'h1F) apply("R5 overlap priority", a);
            else                              apply("R3 claim", a);
        end
        // sweep across the 12-bit split of window 2
        for (int mb = 'hFE0; mb < 'h1020; mb++) begin
            logic [AW-1:0] a;
            a = mk_addr(20'(mb));
            model(a, h, w, x);
            if (h) apply("R4 split bound with wrap", a);
            else   apply("R8 miss near split", a);
        end
        apply("R3 exact start", 40'h00_0100_0000);
        apply("R3 exact end", 40'h00_02FF_FFFF);
        apply("R4 wrap at end", 40'h01_010F_FFFF);
        apply("R8 top address", 40'hFF_FFFF_FFFF);

        // R7: back-to-back requests then idle cycles
        a0 = 40'h00_0150_0ABC;
        a1 = 40'h00_2000_0001;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a0;
        @(negedge clk);
        model(a0, h, w, x);
        check_rsp("R7 back-to-back first", 1'b1, h, !h, w, x);
        req_addr = a1;
        @(negedge clk);
        req_valid = 1'b0;
        model(a1, h, w, x);
        check_rsp("R7 back-to-back second", 1'b1, h, !h, w, x);
        @(negedge clk);
        check_rsp("R7 idle after request", 1'b0, 1'b0, 1'b0, 2'd0, 64'd0);
        @(negedge clk);
        check_rsp("R7 idle steady", 1'b0, 1'b0, 1'b0, 2'd0, 64'd0);

        // R2: offsets 5..7 and junk data bits have no effect
        cfg_wr(5'd5, 32'hFFFF_FFFF);
        cfg_wr(5'd6, 32'hFFFF_FFFF);
        cfg_wr(5'd7, 32'hFFFF_FFFF);
        apply("R2 spare offsets ignored", 40'h00_0120_0F00);
        apply("R2 spare offsets ignored start", 40'h00_0100_0000);

        // R9: write in the same cycle as a request uses old bounds
        a0 = 40'h00_0450_0042;
        model(a0, h, w, x);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 5'd26; cfg_wdata = {12'h04F, 4'h0, 12'h040, 4'h0};
        req_valid = 1'b1; req_addr = a0;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        check_rsp("R9 same-cycle write not seen", 1'b1, h, !h, w, x);
        sh_end[3] = 20'h0004F;
        apply("R9 write seen next request", a0);
        apply("R6 re-enabled window end", 40'h00_04FF_FFFF);
        apply("R8 beyond re-enabled window", 40'h00_0500_0000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule